// File: doc/BRIEF.md
# 48-bit Saturating Register Shifter

This unit shifts a 64-bit operand by a signed amount that comes from a general register. The same amount applies to the whole value. A positive amount shifts left and a negative amount shifts right. Right shifts can round to nearest, with halves rounded up. The shifted value is then clamped to a 48-bit signed or unsigned range and returned inside the 64-bit container, sign-extended or zero-extended. A wide mode clamps to the full 64-bit range instead, so the two behaviours can be compared.

The shift, rounding and range check are combinational. One register stage holds the result and a saturation flag. A request is accepted on any cycle where `opValid` is high, and its answer appears on the next cycle. Overflow on a left shift is found by shifting, re-extending from the top bit of the target width and shifting back. A right shift or a zero shift can also saturate: an input with bits 63..48 set may still lie outside the 48-bit range after the shift.

Top module: `sat_shift48`

## Requirements
- R1: While `rstN` is low, `resValid`, `result` and `satFlag` are all zero.
- R2: A request sampled with `opValid` high produces its result, with `resValid` high, on the following clock edge. On a cycle with `opValid` low, `resValid` is low on the next cycle and `result` and `satFlag` hold their values.
- R3: `shiftAmt` is an 8-bit two's-complement number. A value from 0 to 127 shifts left by that many places, and the exact product is returned when it fits the selected range.
- R4: A left shift whose exact product leaves the selected range saturates to the limit on the operand's side. A left shift by at least the saturation width (48, or 64 in wide mode) saturates any nonzero operand. A zero operand always gives zero with no saturation.
- R5: A shift amount from -1 to -128 shifts right by its magnitude. The shift is arithmetic when `isSigned` is 1 and logical when it is 0. Without rounding, a right shift by 64 or more gives -1 for a negative signed operand and 0 otherwise.
- R6: When `doRound` is 1, a right shift by n first adds 2^(n-1), which rounds halves toward positive infinity. Examples: 7 >> 1 gives 4 and -5 >> 1 gives -2. An unsigned 2^63 shifted right by 64 gives 1. `doRound` has no effect on left shifts or on a zero shift.
- R7: Right shifts and zero shifts are also range-checked. An operand whose bits 63..48 place it outside the 48-bit range saturates even when it is shifted right.
- R8: In signed 48-bit mode (`wideSat`=0) the limits are 0x00007FFFFFFFFFFF and 0xFFFF800000000000, the latter being -(2^47) sign-extended. Every result has bits 63..47 all equal.
- R9: In unsigned 48-bit mode the upper limit is 0x0000FFFFFFFFFFFF and the lower limit is 0. Every result has bits 63..48 equal to zero.
- R10: With `wideSat`=1 the limits become 0x7FFFFFFFFFFFFFFF and 0x8000000000000000 when signed, and 0xFFFFFFFFFFFFFFFF when unsigned.
- R11: `satFlag` is 1 exactly when the returned value differs from the exact mathematical result. When it is 1, `result` is one of the limits of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request strobe |
| operand | input | 64 | Value to shift |
| shiftAmt | input | 8 | Signed shift amount; positive shifts left |
| isSigned | input | 1 | 1: signed operand and range; 0: unsigned |
| doRound | input | 1 | 1: round right shifts |
| wideSat | input | 1 | 1: saturate to 64 bits; 0: saturate to 48 bits |
| resValid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Shifted and saturated value |
| satFlag | output | 1 | Result was clamped |

## Verification
On every cycle the assertions check the following:
- the one-cycle valid timing and the hold behaviour;
- that a 48-bit result is properly sign- or zero-extended;
- that a raised `satFlag` comes with a legal limit value;
- that a zero operand never saturates;
- that a far left shift of a nonzero value always saturates.

Whether the value is right in each case can only be shown by the bench's scenarios. That covers the rounding arithmetic, right shifts saturating because of set upper bits, the exact limit chosen on each side, and wide mode against narrow mode. The bench compares each request against an exact model built on wide integers.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
  localparam int DATA_W     = 64;
  localparam int NARROW_W   = 48;
  localparam int AMT_W      = 8;
  // right-shift working width: sign bit plus one carry bit above the data
  localparam int EXT_W      = DATA_W + 2;
  localparam int MAG_W      = AMT_W;
  localparam int SHL_W      = $clog2(DATA_W);
  localparam int NUM_WIDTHS = 2;

  // strobes from the decoder into the datapath
  typedef struct packed {
    logic             load;
    logic             leftDir;
    logic             farLeft;
    logic             addRound;
    logic             signedOp;
    logic             wide;
    logic [SHL_W-1:0] leftAmt;
    logic [MAG_W-1:0] rightAmt;
  } shiftCtlT;
endpackage

// File: rtl/sat_shift_ctrl.sv
module sat_shift_ctrl
  import sat_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             isSigned,
  input  logic             doRound,
  input  logic             wideSat,
  output shiftCtlT         ctl,
  output logic             resValid
);
  logic             negDir;
  logic [MAG_W-1:0] mag;
  logic [MAG_W:0]   satWidth;

  always_comb begin
    negDir   = shiftAmt[AMT_W-1];
    mag      = negDir ? (~shiftAmt + 1'b1) : shiftAmt;
    satWidth = wideSat ? (MAG_W+1)'(DATA_W) : (MAG_W+1)'(NARROW_W);

    ctl.load     = opValid;
    ctl.leftDir  = !negDir;
    ctl.farLeft  = !negDir && ({1'b0, mag} >= satWidth);
    ctl.addRound = negDir && doRound;
    ctl.signedOp = isSigned;
    ctl.wide     = wideSat;
    ctl.leftAmt  = mag[SHL_W-1:0];
    // beyond DATA_W+1 every right shift gives the same answer
    ctl.rightAmt = (mag > MAG_W'(DATA_W + 1)) ? MAG_W'(DATA_W + 1) : mag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= opValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);
endmodule

// File: rtl/sat_shift_dp.sv
module sat_shift_dp
  import sat_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtlT          ctl,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] N_SMAX   = ALL_ONES >> (DATA_W - NARROW_W + 1);
  localparam logic [DATA_W-1:0] N_UMAX   = ALL_ONES >> (DATA_W - NARROW_W);
  localparam logic [DATA_W-1:0] W_SMAX   = ALL_ONES >> 1;

  logic [DATA_W-1:0]        shifted;
  logic signed [EXT_W-1:0]  xWide;
  logic signed [EXT_W-1:0]  roundAdd;
  logic signed [EXT_W-1:0]  sum;
  logic signed [EXT_W-1:0]  rShift;
  logic [NUM_WIDTHS-1:0]    leftBad;
  logic [NUM_WIDTHS-1:0]    rightBad;
  logic [DATA_W-1:0]        posLim [NUM_WIDTHS];

  always_comb begin
    shifted  = operand << ctl.leftAmt;
    xWide    = {{2{ctl.signedOp & operand[DATA_W-1]}}, operand};
    roundAdd = (ctl.addRound && ctl.rightAmt != '0)
               ? (EXT_W'(1) << (ctl.rightAmt - 1'b1)) : '0;
    sum      = xWide + roundAdd;
    rShift   = sum >>> ctl.rightAmt;
  end

  // one range checker per saturation width
  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int W = (g == 0) ? NARROW_W : DATA_W;
    logic [DATA_W-1:0]       lExt;
    logic [DATA_W-1:0]       lBack;
    logic signed [EXT_W-1:0] rExt;

    if (W < DATA_W) begin : g_narrow
      always_comb
        lExt = ctl.signedOp ? {{(DATA_W-W){shifted[W-1]}}, shifted[W-1:0]}
                            : {{(DATA_W-W){1'b0}}, shifted[W-1:0]};
    end else begin : g_full
      always_comb lExt = shifted;
    end

    always_comb begin
      lBack = ctl.signedOp ? DATA_W'($signed(lExt) >>> ctl.leftAmt)
                           : (lExt >> ctl.leftAmt);
      leftBad[g] = (lBack != operand);
      rExt = ctl.signedOp ? {{(EXT_W-W){rShift[W-1]}}, rShift[W-1:0]}
                          : {{(EXT_W-W){1'b0}}, rShift[W-1:0]};
      rightBad[g] = (rExt != rShift);
      posLim[g] = ctl.signedOp ? (ALL_ONES >> (DATA_W - W + 1))
                               : (ALL_ONES >> (DATA_W - W));
    end
  end

  logic              overflow;
  logic              negSide;
  logic [DATA_W-1:0] satVal;
  logic [DATA_W-1:0] nextVal;
  logic              resSigned;
  logic              resWide;

  always_comb begin
    if (ctl.leftDir)
      overflow = ctl.farLeft ? (operand != '0) : leftBad[ctl.wide];
    else
      overflow = rightBad[ctl.wide];
    negSide = ctl.leftDir ? xWide[EXT_W-1] : rShift[EXT_W-1];
    satVal  = negSide ? ~posLim[ctl.wide] : posLim[ctl.wide];
    nextVal = overflow ? satVal
                       : (ctl.leftDir ? shifted : rShift[DATA_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      satFlag   <= 1'b0;
      resSigned <= 1'b0;
      resWide   <= 1'b0;
    end else if (ctl.load) begin
      result    <= nextVal;
      satFlag   <= overflow;
      resSigned <= ctl.signedOp;
      resWide   <= ctl.wide;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(result) && $stable(satFlag));
  // R8
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!resWide && resSigned) |-> (result[DATA_W-1:NARROW_W-1] == '0 ||
                                 result[DATA_W-1:NARROW_W-1] == '1));
  // R9
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!resWide && !resSigned) |-> (result[DATA_W-1:NARROW_W] == '0));
  // R11
  sat_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    satFlag |-> (result == N_SMAX || result == ~N_SMAX || result == N_UMAX ||
                 result == W_SMAX || result == ~W_SMAX || result == ALL_ONES));
  // R4
  zero_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && operand == '0) |=> (result == '0 && !satFlag));
  // R4
  far_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.farLeft && operand != '0) |=> satFlag);
endmodule

// File: rtl/sat_shift48.sv
module sat_shift48
  import sat_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              isSigned,
  input  logic              doRound,
  input  logic              wideSat,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);
  shiftCtlT ctl;

  sat_shift_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .shiftAmt(shiftAmt),
    .isSigned(isSigned), .doRound(doRound), .wideSat(wideSat),
    .ctl(ctl), .resValid(resValid)
  );

  sat_shift_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operand(operand),
    .result(result), .satFlag(satFlag)
  );
endmodule

// File: tb/sat_shift48_test.sv
`timescale 1ns/1ps
module sat_shift48_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [63:0] operand = '0;
  logic [7:0]  shiftAmt = '0;
  logic        isSigned = 1'b0;
  logic        doRound = 1'b0;
  logic        wideSat = 1'b0;
  logic        resValid;
  logic [63:0] result;
  logic        satFlag;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sat_shift48 uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .operand(operand),
    .shiftAmt(shiftAmt), .isSigned(isSigned), .doRound(doRound),
    .wideSat(wideSat), .resValid(resValid), .result(result), .satFlag(satFlag)
  );

  // exact model on wide integers, then clamp
  function automatic void refModel(input logic [63:0] op, input logic [7:0] amt,
                                   input logic sgn, input logic rnd, input logic wd,
                                   output logic [63:0] res, output logic sat);
    logic signed [255:0] x, ex, hi, lo;
    int s, n, w;
    x = sgn ? {{192{op[63]}}, op} : {192'b0, op};
    s = int'($signed(amt));
    if (s >= 0) ex = x <<< s;
    else begin
      n = -s;
      if (rnd) ex = (x + (256'sd1 <<< (n - 1))) >>> n;
      else     ex = x >>> n;
    end
    w = wd ? 64 : 48;
    if (sgn) begin
      hi = (256'sd1 <<< (w - 1)) - 256'sd1;
      lo = -(256'sd1 <<< (w - 1));
    end else begin
      hi = (256'sd1 <<< w) - 256'sd1;
      lo = '0;
    end
    if (ex > hi)      begin res = hi[63:0]; sat = 1'b1; end
    else if (ex < lo) begin res = lo[63:0]; sat = 1'b1; end
    else              begin res = ex[63:0]; sat = 1'b0; end
  endfunction

  task automatic apply(input logic [63:0] op, input logic [7:0] amt,
                       input logic sgn, input logic rnd, input logic wd,
                       input string tag);
    logic [63:0] er;
    logic es;
    refModel(op, amt, sgn, rnd, wd, er, es);
    @(negedge clk);
    operand = op; shiftAmt = amt; isSigned = sgn; doRound = rnd; wideSat = wd;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    vectors++;
    if (resValid !== 1'b1 || result !== er || satFlag !== es) begin
      miscompares++;
      $display("FAIL %s op=%h amt=%0d s=%b r=%b w=%b: got %h sat=%b vld=%b, expected %h sat=%b vld=1",
               tag, op, $signed(amt), sgn, rnd, wd, result, satFlag, resValid, er, es);
    end
  endtask

  task automatic holdCheck();
    logic [63:0] prevRes;
    logic prevSat;
    prevRes = result; prevSat = satFlag;
    @(negedge clk);
    operand = ~operand; shiftAmt = 8'd3; opValid = 1'b0;
    @(negedge clk);
    vectors++;
    if (resValid !== 1'b0 || result !== prevRes || satFlag !== prevSat) begin
      miscompares++;
      $display("FAIL R2 hold: got %h sat=%b vld=%b, expected %h sat=%b vld=0",
               result, satFlag, resValid, prevRes, prevSat);
    end
  endtask

  function automatic logic [63:0] randOperand();
    logic [63:0] v;
    case ($urandom % 5)
      0: v = {$urandom, $urandom};
      1: v = {{48{1'b0}}, 16'($urandom)};
      2: v = {16'($urandom | 1), 48'({$urandom, $urandom})};
      3: v = 64'd1 << ($urandom % 64);
      default: v = -(64'd1 << ($urandom % 64));
    endcase
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state, even with a request on the inputs
    opValid = 1'b1; operand = 64'h1234; shiftAmt = 8'd2;
    repeat (3) @(negedge clk);
    vectors++;
    if (resValid !== 1'b0 || result !== '0 || satFlag !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: got %h sat=%b vld=%b, expected 0 sat=0 vld=0",
               result, satFlag, resValid);
    end
    opValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R3 plain left shifts
    apply(64'd5, 8'd4, 1'b1, 1'b0, 1'b0, "R3");
    apply(-64'd3, 8'd10, 1'b1, 1'b0, 1'b0, "R3");
    apply(64'h0000_0000_00AB_CDEF, 8'd20, 1'b0, 1'b0, 1'b0, "R3");
    // R4 overflow on left shifts
    apply(64'd1 << 44, 8'd3, 1'b1, 1'b0, 1'b0, "R4");
    apply(64'd1 << 44, 8'd4, 1'b1, 1'b0, 1'b0, "R4");
    apply(-(64'd1 << 44), 8'd3, 1'b1, 1'b0, 1'b0, "R4");
    apply(-(64'd1 << 44), 8'd4, 1'b1, 1'b0, 1'b0, "R4");
    apply(64'd1, 8'd48, 1'b1, 1'b0, 1'b0, "R4");
    apply(-64'd1, 8'd100, 1'b1, 1'b0, 1'b0, "R4");
    apply(64'd0, 8'd127, 1'b1, 1'b0, 1'b0, "R4");
    holdCheck();
    // R5 right shifts
    apply(-64'd256, 8'hFC, 1'b1, 1'b0, 1'b0, "R5");
    apply(-64'd256, 8'hFC, 1'b0, 1'b0, 1'b1, "R5");
    apply(-64'd7, 8'h9C, 1'b1, 1'b0, 1'b0, "R5");
    apply(64'd12345, 8'h80, 1'b1, 1'b0, 1'b0, "R5");
    apply(-64'd1, 8'hC0, 1'b0, 1'b0, 1'b1, "R5");
    // R6 rounding
    apply(64'd7, 8'hFF, 1'b1, 1'b1, 1'b0, "R6");
    apply(-64'd5, 8'hFF, 1'b1, 1'b1, 1'b0, "R6");
    apply(64'd3, 8'd1, 1'b1, 1'b1, 1'b0, "R6");
    apply(64'h8000_0000_0000_0000, 8'hC0, 1'b0, 1'b1, 1'b1, "R6");
    apply(-64'd1, 8'h80, 1'b1, 1'b1, 1'b0, "R6");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 8'hBF, 1'b0, 1'b1, 1'b1, "R6");
    // R7 right and zero shifts still range-checked
    apply(64'h7FFF_0000_0000_0000, 8'hFC, 1'b1, 1'b0, 1'b0, "R7");
    apply(64'h7FFF_0000_0000_0000, 8'hF0, 1'b1, 1'b0, 1'b0, "R7");
    apply(64'd1 << 47, 8'd0, 1'b1, 1'b0, 1'b0, "R7");
    apply(64'h8000_1234_0000_0000, 8'hF8, 1'b1, 1'b1, 1'b0, "R7");
    // R8 signed 48-bit limits
    apply(-(64'd1 << 47), 8'd0, 1'b1, 1'b0, 1'b0, "R8");
    apply(-(64'd1 << 47) - 64'd1, 8'd0, 1'b1, 1'b0, 1'b0, "R8");
    apply((64'd1 << 47) - 64'd1, 8'd0, 1'b1, 1'b1, 1'b0, "R8");
    // R9 unsigned 48-bit limits
    apply(64'd1 << 47, 8'd1, 1'b0, 1'b0, 1'b0, "R9");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 1'b0, 1'b0, 1'b0, "R9");
    apply(64'h0000_FFFF_FFFF_FFFF, 8'd0, 1'b0, 1'b0, 1'b0, "R9");
    // R10 wide mode
    apply(64'd1 << 62, 8'd1, 1'b1, 1'b0, 1'b1, "R10");
    apply(-(64'd1 << 62), 8'd2, 1'b1, 1'b0, 1'b1, "R10");
    apply(64'd1 << 47, 8'd0, 1'b1, 1'b0, 1'b1, "R10");
    apply(64'd3, 8'd63, 1'b0, 1'b0, 1'b1, "R10");
    apply(64'd1, 8'd64, 1'b0, 1'b0, 1'b1, "R10");
    holdCheck();

    // R11 random mix against the exact model
    for (int i = 0; i < 600; i++) begin
      logic [7:0] amt;
      if ($urandom % 2 == 0) amt = 8'($urandom);
      else amt = 8'(int'($urandom % 141) - 70);
      apply(randOperand(), amt, 1'($urandom), 1'($urandom), 1'($urandom), "R11");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule